// File: doc/BRIEF.md
# Dual-Lane Q15 Rounding Fractional Multiplier

This block multiplies two packed 32-bit words lane by lane. Each word carries two signed Q15 halfwords. Q15 means one sign bit and fifteen fraction bits, so a lane spans -1.0 (0x8000) up to 0x7FFF, which is just under +1.0. The signed product of each lane pair is doubled to keep the fractional scale. It can then be rounded to nearest. Its upper sixteen bits go back into the same lane position of the packed result, so the output elements have the same width as the inputs.

The value +1.0 has no Q15 encoding, so -1.0 times -1.0 is the single case that overflows. With saturation enabled, that lane is clamped to 0x7FFF. With saturation disabled, the doubled product wraps to 0x8000. In both modes a one-cycle overflow pulse is raised alongside the result strobe, so that an external sticky status bit can record the event. The datapath is combinational and ends in one register stage. A request presented with `valid_i` appears on the outputs one clock later.

Top module: `q15_pair_mul`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `result_o` and `ovf_o` are all zero.
- R2: Bits 31:16 of `result_o` depend only on bits 31:16 of both sources, and bits 15:0 depend only on bits 15:0. A clamp in one lane leaves the other lane's value unchanged.
- R3: With rounding off, a lane result is bits 31:16 of the 32-bit two's-complement value 2·a·b, where a and b are the signed 16-bit lane operands.
- R4: With rounding on, 0x00008000 is added modulo 2^32 to the doubled product before bits 31:16 are taken.
- R5: With saturation on and both lane operands equal to 0x8000, the lane result is 0x7FFF, whatever the rounding mode.
- R6: With saturation off and both lane operands equal to 0x8000, the lane result is 0x8000, whatever the rounding mode.
- R7: `ovf_o` is high in a cycle exactly when `valid_o` is high and the captured request had at least one lane with both operands equal to 0x8000. This holds whatever the saturation mode.
- R8: `valid_o` is high exactly one clock after a clock edge at which `valid_i` was high. `ovf_o` is never high while `valid_o` is low.
- R9: A clock edge with `valid_i` low leaves `result_o` unchanged, whatever the values on the source and mode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe; sources and modes are captured when high |
| round_en_i | input | 1 | Round each lane to nearest |
| sat_en_i | input | 1 | Clamp the -1.0 × -1.0 lane case to 0x7FFF |
| src_a_i | input | 32 | First packed source; lane 1 in bits 31:16, lane 0 in bits 15:0 |
| src_b_i | input | 32 | Second packed source, same layout |
| valid_o | output | 1 | Result strobe, one cycle after the request |
| result_o | output | 32 | Packed Q15 products, same lane layout |
| ovf_o | output | 1 | One-cycle overflow pulse qualified by valid_o |

## Verification
Several checks run on every cycle: the one-cycle latency of the strobe, that the overflow pulse never appears without the strobe, that the result holds on idle cycles, and that each lane takes the value required for the -1.0 × -1.0 case under each saturation mode. The arithmetic of ordinary lanes can only be shown by the bench's scenarios, which a behavioural integer model compares on every clock. These scenarios are the truncation and rounding of positive and negative products, lane placement with distinct values per lane, and one lane clamping while the other computes normally.

// File: rtl/q15_pkg.sv
package q15_pkg;
  parameter int LANE_W    = 16;
  parameter int NUM_LANES = 2;
  localparam int DATA_W   = LANE_W * NUM_LANES;

  typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/q15_lane_mul.sv
module q15_lane_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         round_en_i,
  input  logic         sat_en_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam int          PW    = 2 * W;
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = ~MIN_V;
  localparam logic [PW-1:0] RND  = PW'(1) << (W - 1);

  logic signed [PW-1:0] prod;
  logic [PW-1:0]        scaled;
  logic [PW-1:0]        rounded;
  logic                 both_min;

  always_comb begin
    prod     = PW'($signed(a_i)) * PW'($signed(b_i));
    scaled   = {prod[PW-2:0], 1'b0};        // Q(2W-2) -> Q(2W-1)
    rounded  = scaled + (round_en_i ? RND : '0);
    both_min = (a_i == MIN_V) && (b_i == MIN_V);
    res_o    = (sat_en_i && both_min) ? MAX_V : rounded[PW-1:W];
    ovf_o    = both_min;
  end
endmodule

// File: rtl/q15_out_reg.sv
module q15_out_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          flag_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      flag_o  <= 1'b0;
    end else begin
      valid_o <= load_i;
      flag_o  <= load_i & flag_i;
      if (load_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/q15_pair_mul.sv
module q15_pair_mul
  import q15_pkg::*;
#(
  parameter int LW = q15_pkg::LANE_W,
  parameter int NL = q15_pkg::NUM_LANES
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic           round_en_i,
  input  logic           sat_en_i,
  input  logic [31:0]    src_a_i,
  input  logic [31:0]    src_b_i,
  output logic           valid_o,
  output logic [31:0]    result_o,
  output logic           ovf_o
);
  localparam int DW = LW * NL;
  localparam logic [LW-1:0] MIN_V = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] MAX_V = ~MIN_V;

  logic [DW-1:0] lane_res;
  logic [NL-1:0] lane_ovf;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    q15_lane_mul #(.W(LW)) u_lane (
      .a_i       (src_a_i[g*LW +: LW]),
      .b_i       (src_b_i[g*LW +: LW]),
      .round_en_i(round_en_i),
      .sat_en_i  (sat_en_i),
      .res_o     (lane_res[g*LW +: LW]),
      .ovf_o     (lane_ovf[g])
    );

    // R5
    sat_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && sat_en_i && src_a_i[g*LW +: LW] == MIN_V && src_b_i[g*LW +: LW] == MIN_V)
      |=> result_o[g*LW +: LW] == MAX_V);

    // R6
    wrap_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !sat_en_i && src_a_i[g*LW +: LW] == MIN_V && src_b_i[g*LW +: LW] == MIN_V)
      |=> result_o[g*LW +: LW] == MIN_V);

    // R7
    lane_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && src_a_i[g*LW +: LW] == MIN_V && src_b_i[g*LW +: LW] == MIN_V)
      |=> ovf_o);
  end

  q15_out_reg #(.DW(DW)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (valid_i),
    .data_i (lane_res),
    .flag_i (|lane_ovf),
    .valid_o(valid_o),
    .data_o (result_o),
    .flag_o (ovf_o)
  );

  // R8
  strobe_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R8
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R8
  ovf_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> valid_o);

  // R9
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
endmodule

// File: tb/q15_pair_mul_tb.sv
module q15_pair_mul_tb;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i = 1'b0, round_en_i = 1'b0, sat_en_i = 1'b0;
  logic [31:0] src_a_i = '0, src_b_i = '0;
  logic        valid_o, ovf_o;
  logic [31:0] result_o;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] exp_res = '0;
  logic        exp_valid = 1'b0, exp_ovf = 1'b0;

  always #10 clk = ~clk;

  q15_pair_mul u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .round_en_i(round_en_i), .sat_en_i(sat_en_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i),
    .valid_o(valid_o), .result_o(result_o), .ovf_o(ovf_o)
  );

  function automatic logic [15:0] ref_lane(logic [15:0] a, logic [15:0] b, logic rnd, logic sat);
    int          p;
    logic [31:0] s;
    if (sat && a == 16'h8000 && b == 16'h8000) return 16'h7fff;
    p = int'($signed(a)) * int'($signed(b));
    s = 32'(p) << 1;
    if (rnd) s = s + 32'h0000_8000;
    return s[31:16];
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, model the capturing edge, compare at the next negedge
  task automatic step(string tag, logic v, logic rnd, logic sat, logic [31:0] a, logic [31:0] b);
    valid_i = v; round_en_i = rnd; sat_en_i = sat; src_a_i = a; src_b_i = b;
    @(posedge clk);
    exp_valid = v;
    if (v) begin
      exp_res = {ref_lane(a[31:16], b[31:16], rnd, sat), ref_lane(a[15:0], b[15:0], rnd, sat)};
      exp_ovf = (a[31:16] == 16'h8000 && b[31:16] == 16'h8000) ||
                (a[15:0]  == 16'h8000 && b[15:0]  == 16'h8000);
    end else begin
      exp_ovf = 1'b0;
    end
    @(negedge clk);
    check(tag, "valid_o",  {31'b0, valid_o}, {31'b0, exp_valid});
    check(tag, "result_o", result_o, exp_res);
    check(tag, "ovf_o",    {31'b0, ovf_o}, {31'b0, exp_ovf});
  endtask

  initial begin
    logic [31:0] seed;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    #4;
    check("R1", "valid_o",  {31'b0, valid_o}, 32'd0);
    check("R1", "result_o", result_o, 32'd0);
    check("R1", "ovf_o",    {31'b0, ovf_o}, 32'd0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;

    // R2: distinct lane values, placement
    step("R2", 1, 0, 0, 32'h4000_2000, 32'h4000_0800);
    check("R2", "left lane",  {16'b0, result_o[31:16]}, 32'h2000);
    check("R2", "right lane", {16'b0, result_o[15:0]},  32'h0200);
    step("R2", 1, 0, 0, 32'hC000_1234, 32'h2000_7FFF);
    // R3: truncation of small positive and negative products
    step("R3", 1, 0, 0, 32'h0003_FFFD, 32'h4000_4000);
    check("R3", "trunc lanes", result_o, 32'h0001_FFFE);
    // R4: rounding of the same products
    step("R4", 1, 1, 0, 32'h0003_FFFD, 32'h4000_4000);
    check("R4", "round lanes", result_o, 32'h0002_FFFF);
    // R5 / R7: clamp both lanes, overflow flagged
    step("R5", 1, 0, 1, 32'h8000_8000, 32'h8000_8000);
    check("R5", "clamp", result_o, 32'h7FFF_7FFF);
    step("R5", 1, 1, 1, 32'h8000_8000, 32'h8000_8000);
    // R6 / R7: wrap without saturation, still flagged
    step("R6", 1, 0, 0, 32'h8000_8000, 32'h8000_8000);
    check("R6", "wrap", result_o, 32'h8000_8000);
    check("R7", "ovf without sat", {31'b0, ovf_o}, 32'd1);
    step("R6", 1, 1, 0, 32'h8000_8000, 32'h8000_8000);
    // R2 / R5: one lane clamps, the other computes normally
    step("R2", 1, 0, 1, 32'h8000_8000, 32'h8000_4000);
    check("R2", "mixed lanes", result_o, 32'h7FFF_C000);
    // R7: -1.0 times other values does not flag
    step("R7", 1, 0, 1, 32'h8000_7FFF, 32'h8001_8000);
    check("R7", "no ovf", {31'b0, ovf_o}, 32'd0);
    // R9: idle cycles with moving inputs
    step("R9", 0, 1, 1, 32'h8000_8000, 32'h8000_8000);
    check("R9", "hold", result_o, 32'h7FFF_0000 | {16'b0, ref_lane(16'h7FFF, 16'h8000, 0, 1)});
    step("R9", 0, 0, 0, 32'h1234_5678, 32'h9ABC_DEF0);
    // R8: back-to-back then idle
    step("R8", 1, 0, 0, 32'h0100_0100, 32'h0100_0100);
    step("R8", 1, 1, 0, 32'h8000_0001, 32'h8000_0001);
    step("R8", 0, 0, 0, 32'h0, 32'h0);
    // sweep of all modes
    seed = 32'h1ACE_B00C;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
      if (i % 7 == 0) a[15:0] = 16'h8000;
      if (i % 5 == 0) b[15:0] = 16'h8000;
      if (i % 11 == 0) begin a[31:16] = 16'h8000; b[31:16] = 16'h8000; end
      step("R3", (i % 4) != 3, i[0], i[1], a, b);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule